// File: doc/BRIEF.md
# DRAM Strobe-Cycle Decoder with Refresh Counter and Bit-Compare Test Mode

This block models the control logic of an asynchronous 1M x 2 DRAM as synchronous logic. A fast system clock samples the active-low row strobe, the two column strobes, the write enable and the output enable. Each falling row strobe is classified by the state of the other strobes at that moment: an addressed row cycle (a normal access or a row-only refresh), a refresh from the internal counter, a hidden refresh, or test-mode entry.

Row and column addresses share a 10-bit bus. The row is captured on the falling row strobe and the column on each falling column strobe, so several columns can be accessed under one row (page mode). Each column strobe selects one data bit. Data is held in a small parameterized array. The output drives only during a read, and only while a column strobe is low and output enable is asserted.

The test mode ignores the lowest column bit. A write stores the data into both columns of the pair. A read returns 11 when all four stored bits of the pair agree and 00 when they do not. The classification, the row used and the test-mode state are brought out for observation.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: When the row strobe falls while both column strobes are high, `cyc_kind` becomes 1 and `cyc_row` becomes the full address bus value. This opens a row for column accesses.
- R2: When the row strobe falls while a column strobe is low and write enable is high, with no column strobe held over from a read, `cyc_kind` becomes 2 and `cyc_row` shows the refresh counter value.
- R3: The refresh counter starts at 0 after reset. It advances by one after every counter-based refresh (kinds 2, 3 and 4) and wraps from 1023 to 0.
- R4: A hidden refresh occurs when the row strobe rises and falls again while a column strobe is still low from a read in the previous row cycle. `cyc_kind` becomes 3, `cyc_row` shows the counter, and the read data stays driven.
- R5: When the row strobe falls with a column strobe low and write enable low, `cyc_kind` becomes 4, `test_mode` becomes 1 and the counter row is refreshed.
- R6: Test mode is cleared by a kind 2 or kind 3 refresh, or by a row-only cycle in which the row strobe rises without any column strobe falling. A row cycle that accesses a column leaves test mode set.
- R7: A read captures the column on the falling column strobe and drives both stored bits on `dout`. `dout_en` is high only while a column strobe is low and `oe_n` is low, and it drops when either of these ends.
- R8: Write enable low at the falling column strobe is an early write. `din[0]` is written when `cas1_n` is low and `din[1]` when `cas2_n` is low, and `dout_en` stays low for that column.
- R9: Write enable falling while a column strobe is low within an open row is a delayed write: `din` is written to the captured column with the same per-strobe bit selection.
- R10: In test mode, column bit 0 is ignored. A write stores into both columns of the pair. A read drives 11 if all four bits of the pair are equal and 00 otherwise.
- R11: Several column strobe falls under one low row strobe each access the column present on the bus at that fall (page mode).
- R12: During and after reset, `dout_en` is 0, `cyc_kind` is 0 and `test_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas1_n | input | 1 | Column strobe for data bit 0, active low |
| cas2_n | input | 1 | Column strobe for data bit 1, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 2 | Write data |
| dout | output | 2 | Read data, valid while dout_en is high |
| dout_en | output | 1 | Output drive enable (low means high impedance) |
| cyc_kind | output | 3 | Last classification: 0 none, 1 row, 2 counter refresh, 3 hidden, 4 test entry |
| cyc_row | output | ADDR_W | Row used by the last row-strobe fall |
| test_mode | output | 1 | Bit-compare test mode active |

## Verification
The bench builds the block with its defaults: a 10-bit address and a 16 x 16 cell array. The small array lets the bench first fill every cell and then make random page bursts that keep landing on cells already written, which exercises masked, early and delayed writes over earlier data. Because the counter keeps its full 10-bit width, a run of just over 1024 counter refreshes reaches the wrap from 1023 to 0. Directed sequences cover test-mode entry, both ways of leaving it, and agreeing and disagreeing compare reads.

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
  parameter int ADDR_W = 10,
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas1_n,
  input  logic              cas2_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        din,
  output logic [1:0]        dout,
  output logic              dout_en,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] cyc_row,
  output logic              test_mode
);
  localparam int CELLS = 1 << (ROW_AW + COL_AW);
  localparam logic [2:0] K_NONE = 3'd0, K_ROW = 3'd1, K_CBR = 3'd2, K_HID = 3'd3, K_WCBR = 3'd4;

  logic [1:0] mem [CELLS];

  logic ras_q, cas_q, we_q;
  logic acc, col_seen, cas_held, rd_valid;
  logic [ROW_AW-1:0] row_r;
  logic [COL_AW-1:0] col_r;
  logic [1:0] rd_data;
  logic [ADDR_W-1:0] ref_cnt;

  wire cas_lo   = ~(cas1_n & cas2_n);
  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_lo & ~cas_q;
  wire we_fall  = we_q & ~we_n;
  wire col_fall = acc & ~ras_n & cas_fall;
  wire wr_ev    = acc & ~ras_n & cas_lo & ~we_n & (cas_fall | we_fall);
  wire [1:0] wmask = {~cas2_n, ~cas1_n};

  wire [COL_AW-1:0] c_new = addr[COL_AW-1:0];
  wire [COL_AW-1:0] wcol  = cas_fall ? c_new : col_r;

  logic [ROW_AW+COL_AW-1:0] ridx0, ridx1;
  logic [ROW_AW+COL_AW-1:0] widx [2];
  logic [1:0] cell_a, cell_b, rd_next;
  logic agree;

  always_comb begin
    ridx0  = {row_r, test_mode ? {c_new[COL_AW-1:1], 1'b0} : c_new};
    ridx1  = {row_r, c_new[COL_AW-1:1], 1'b1};
    cell_a = mem[ridx0];
    cell_b = mem[ridx1];
    agree  = (cell_a == 2'b00 || cell_a == 2'b11) && (cell_a == cell_b);
    rd_next = test_mode ? {2{agree}} : cell_a;
  end

  for (genvar k = 0; k < 2; k++) begin : g_widx
    assign widx[k] = {row_r, test_mode ? {wcol[COL_AW-1:1], 1'(k)} : wcol};
  end

  always_ff @(posedge clk) begin
    if (wr_ev) begin
      for (int k = 0; k < 2; k++) begin
        if (wmask[0]) mem[widx[k]][0] <= din[0];
        if (wmask[1]) mem[widx[k]][1] <= din[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b0; we_q <= 1'b1;
      acc <= 1'b0; col_seen <= 1'b0; cas_held <= 1'b0; rd_valid <= 1'b0;
      row_r <= '0; col_r <= '0; rd_data <= '0; ref_cnt <= '0;
      cyc_kind <= K_NONE; cyc_row <= '0; test_mode <= 1'b0;
    end else begin
      ras_q <= ras_n; cas_q <= cas_lo; we_q <= we_n;
      if (ras_fall) begin
        if (!cas_lo) begin
          cyc_kind <= K_ROW;
          cyc_row  <= addr;
          row_r    <= addr[ROW_AW-1:0];
          acc      <= 1'b1;
          col_seen <= 1'b0;
        end else begin
          cyc_row <= ref_cnt;
          ref_cnt <= ref_cnt + 1'b1;
          if (!we_n) begin
            cyc_kind  <= K_WCBR;
            test_mode <= 1'b1;
          end else begin
            cyc_kind  <= cas_held ? K_HID : K_CBR;
            test_mode <= 1'b0;
          end
        end
      end
      if (ras_rise) begin
        acc <= 1'b0;
        if (acc && !col_seen) test_mode <= 1'b0;
      end
      if (col_fall) begin
        col_r    <= c_new;
        col_seen <= 1'b1;
        cas_held <= 1'b1;
        rd_valid <= we_n;
        rd_data  <= rd_next;
      end
      if (wr_ev) rd_valid <= 1'b0;
      if (!cas_lo) begin
        cas_held <= 1'b0;
        rd_valid <= 1'b0;
      end
    end
  end

  assign dout    = rd_data;
  assign dout_en = rd_valid & ~oe_n & cas_lo;

  a_r1_row_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && !cas_lo |=> cyc_kind == K_ROW && cyc_row == $past(addr));
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && cas_lo |=> ref_cnt == ADDR_W'($past(ref_cnt) + 1'b1));
  a_r5_test_enter: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && cas_lo && !we_n |=> test_mode);
  a_r6_test_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && cas_lo && we_n |=> !test_mode);
  a_r8_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    col_fall && !we_n |=> !dout_en);
  a_r4_hidden_data: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && cas_lo && we_n && dout_en |=> dout_en || oe_n || !cas_lo);
endmodule

// File: tb/dram_cycle_ctrl_bench.sv
module dram_cycle_ctrl_bench;
  localparam int AW = 10, RA = 4, CA = 4, CELLS = 1 << (RA + CA);

  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cas1_n = 1, cas2_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [1:0] din = '0;
  logic [1:0] dout;
  logic dout_en, test_mode;
  logic [2:0] cyc_kind;
  logic [AW-1:0] cyc_row;

  int checks = 0, errors = 0, cnt = 0;
  logic [1:0] mdl [CELLS];

  always #2 clk = ~clk;

  dram_cycle_ctrl #(.ADDR_W(AW), .ROW_AW(RA), .COL_AW(CA)) u_dram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas1_n(cas1_n), .cas2_n(cas2_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .cyc_kind(cyc_kind), .cyc_row(cyc_row), .test_mode(test_mode));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  function automatic int idx(input int r, input int c);
    return (r % (1 << RA)) * (1 << CA) + (c % (1 << CA));
  endfunction

  function automatic logic [1:0] merge(input logic [1:0] old, input logic [1:0] m, input logic [1:0] d);
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [1:0] cmp_exp(input int r, input int c);
    logic [1:0] a = mdl[idx(r, c & ~1)], b = mdl[idx(r, c | 1)];
    return ((a == 2'b00 || a == 2'b11) && a == b) ? 2'b11 : 2'b00;
  endfunction

  task automatic open_row(input int r);
    addr = AW'(r); ras_n = 0; tick;
    chk(cyc_kind == 3'd1 && cyc_row == AW'(r), "R1", "row open kind/row", int'(cyc_row), r);
  endtask

  task automatic close_row;
    ras_n = 1; cas1_n = 1; cas2_n = 1; we_n = 1; oe_n = 1; tick; tick;
  endtask

  task automatic rd(input int c, input logic [1:0] exp, input string req);
    addr = AW'(c); we_n = 1; oe_n = 0; cas1_n = 0; cas2_n = 0; tick;
    chk(dout_en && dout == exp, req, "read data", int'({dout_en, dout}), int'({1'b1, exp}));
    cas1_n = 1; cas2_n = 1; tick;
    chk(!dout_en, "R7", "hi-z after column strobe high", int'(dout_en), 0);
    oe_n = 1;
  endtask

  task automatic ewr(input int r, input int c, input logic [1:0] m, input logic [1:0] d, input bit tm);
    addr = AW'(c); din = d; we_n = 0; cas1_n = ~m[0]; cas2_n = ~m[1]; oe_n = 0; tick;
    chk(!dout_en, "R8", "early write output quiet", int'(dout_en), 0);
    cas1_n = 1; cas2_n = 1; we_n = 1; oe_n = 1; tick;
    if (tm) begin
      mdl[idx(r, c & ~1)] = merge(mdl[idx(r, c & ~1)], m, d);
      mdl[idx(r, c | 1)]  = merge(mdl[idx(r, c | 1)], m, d);
    end else mdl[idx(r, c)] = merge(mdl[idx(r, c)], m, d);
  endtask

  task automatic dwr(input int r, input int c, input logic [1:0] m, input logic [1:0] d);
    addr = AW'(c); we_n = 1; oe_n = 1; cas1_n = ~m[0]; cas2_n = ~m[1]; tick;
    we_n = 0; din = d; tick;
    cas1_n = 1; cas2_n = 1; we_n = 1; tick;
    mdl[idx(r, c)] = merge(mdl[idx(r, c)], m, d);
  endtask

  task automatic cbr(input string req);
    cas1_n = 0; cas2_n = 0; we_n = 1; tick;
    ras_n = 0; tick;
    chk(cyc_kind == 3'd2 && cyc_row == AW'(cnt), req, "counter refresh row", int'(cyc_row), cnt);
    cnt = (cnt + 1) % 1024;
    ras_n = 1; tick; cas1_n = 1; cas2_n = 1; tick;
  endtask

  task automatic wcbr;
    cas1_n = 0; cas2_n = 0; we_n = 0; tick;
    ras_n = 0; tick;
    chk(cyc_kind == 3'd4 && test_mode && cyc_row == AW'(cnt), "R5", "test entry", int'(cyc_row), cnt);
    cnt = (cnt + 1) % 1024;
    ras_n = 1; tick; cas1_n = 1; cas2_n = 1; we_n = 1; tick;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed);
    repeat (3) tick;
    chk(!dout_en && cyc_kind == 0 && !test_mode, "R12", "reset state", int'({dout_en, cyc_kind, test_mode}), 0);
    rst_n = 1; tick;
    chk(!dout_en && cyc_kind == 0 && !test_mode, "R12", "after reset", int'({dout_en, cyc_kind, test_mode}), 0);

    for (int r = 0; r < (1 << RA); r++) begin
      open_row(r);
      for (int c = 0; c < (1 << CA); c++) ewr(r, c, 2'b11, 2'((r * 7 + c) % 4), 0);
      close_row;
    end

    open_row(5);
    rd(1, mdl[idx(5, 1)], "R11");
    rd(2, mdl[idx(5, 2)], "R11");
    rd(3, mdl[idx(5, 3)], "R11");
    addr = AW'(4); oe_n = 1; cas1_n = 0; cas2_n = 0; tick;
    chk(!dout_en, "R7", "OE high keeps hi-z", int'(dout_en), 0);
    oe_n = 0; tick;
    chk(dout_en && dout == mdl[idx(5, 4)], "R7", "OE low drives", int'(dout), int'(mdl[idx(5, 4)]));
    oe_n = 1; tick;
    chk(!dout_en, "R7", "OE release", int'(dout_en), 0);
    cas1_n = 1; cas2_n = 1; tick;
    dwr(5, 9, 2'b11, ~mdl[idx(5, 9)]);
    rd(9, mdl[idx(5, 9)], "R9");
    ewr(5, 10, 2'b01, ~mdl[idx(5, 10)], 0);
    rd(10, mdl[idx(5, 10)], "R8");
    dwr(5, 11, 2'b10, ~mdl[idx(5, 11)]);
    rd(11, mdl[idx(5, 11)], "R9");
    close_row;

    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom % 1024);
      int nb = 1 + int'($urandom % 3);
      open_row(r);
      for (int j = 0; j < nb; j++) begin
        int c = int'($urandom % 1024);
        int op = int'($urandom % 3);
        logic [1:0] m = 2'(1 + $urandom % 3);
        logic [1:0] d = 2'($urandom % 4);
        if (op == 0) rd(c, mdl[idx(r, c)], "R11");
        else if (op == 1) ewr(r, c, m, d, 0);
        else dwr(r, c, m, d);
      end
      close_row;
    end

    for (int i = 0; i < 1030; i++) cbr("R3");
    chk(cnt == 6, "R3", "counter wrapped", cnt, 6);
    cbr("R2");

    open_row(7);
    rd(3, mdl[idx(7, 3)], "R7");
    addr = AW'(6); oe_n = 0; cas1_n = 0; cas2_n = 0; tick;
    ras_n = 1; tick;
    ras_n = 0; tick;
    chk(cyc_kind == 3'd3 && cyc_row == AW'(cnt), "R4", "hidden kind/row", int'(cyc_kind), 3);
    chk(dout_en && dout == mdl[idx(7, 6)], "R4", "hidden keeps data", int'(dout), int'(mdl[idx(7, 6)]));
    cnt = (cnt + 1) % 1024;
    ras_n = 1; tick; cas1_n = 1; cas2_n = 1; oe_n = 1; tick;
    chk(!dout_en, "R7", "hidden end hi-z", int'(dout_en), 0);

    wcbr;
    open_row(3);
    ewr(3, 6, 2'b11, 2'b10, 1);
    rd(7, 2'b00, "R10");
    ewr(3, 7, 2'b11, 2'b11, 1);
    rd(6, 2'b11, "R10");
    close_row;
    chk(test_mode, "R6", "access keeps test mode", int'(test_mode), 1);
    addr = AW'(3); ras_n = 0; tick; close_row;
    chk(!test_mode, "R6", "row-only exit", int'(test_mode), 0);
    open_row(3);
    ewr(3, 7, 2'b11, 2'b01, 0);
    rd(6, mdl[idx(3, 6)], "R10");
    rd(7, 2'b01, "R10");
    close_row;
    wcbr;
    open_row(3);
    rd(6, cmp_exp(3, 6), "R10");
    close_row;
    cbr("R6");
    chk(!test_mode, "R6", "refresh exit", int'(test_mode), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule